// File: doc/BRIEF.md
# Ethernet Frame CRC-32 Generator with Residual-Byte Completion

The block computes the Ethernet frame check sequence over a stream of 32-bit words carrying four bytes per clock. A frame opens with a start-of-frame flag on its first valid word and closes with an end-of-frame flag on its last valid word. A residual count on that last word tells the block how many of its bytes belong to the frame. The finished CRC appears one clock after the closing word, together with a one-cycle done strobe.

The Ethernet conventions are built in. The state starts at all ones. Each byte enters the update with its bits reversed. The result leaves inverted and bit-reversed over all 32 bits. A last word with one, two or three bytes is finished in the same clock by a narrower update network. The narrow network carries on from the running state. The word is never padded and the state is not reset. A transmitter appending the check field, or a receiver comparing one, instantiates this block and uses `crc_o` directly.

Top module: `crc32_eth_residual`

## Requirements
- R1: While `rst_ni` is low and after its release, `done_o` is 0 and `crc_o` is 32'h0 until the first frame completes.
- R2: The block uses polynomial 0x04C11DB7 with all-ones start, per-byte bit reversal on input, and inversion plus full 32-bit reversal on output. The single-word frame with bytes 01,02,03,04 (data 32'h04030201) yields 32'hB63CFBCD.
- R3: Byte k of the stream sits in `data_i[8k+7:8k]`, so the first byte in frame order is `data_i[7:0]`.
- R4: A valid word with `sof_i`=1 starts from the all-ones state, whatever earlier frames left behind.
- R5: On a valid word with `eof_i`=1, `cnt_i` gives the number of frame bytes: 1, 2 or 3 take bytes 0..cnt_i-1, and 0 means all four. The unused upper bytes have no effect on `crc_o`.
- R6: A frame of any length covers all its full words and then its residual bytes, continuing from the running state. The 24-byte frame 01 02 03 04 05 06 F1 F2 F3 F4 F5 F6 00 01 .. 0B yields 32'h06654188.
- R7: While `valid_i` is 0, the running state holds, and `sof_i`, `eof_i` and `data_i` are ignored.
- R8: `done_o` is 1 for exactly the one cycle after each valid end-of-frame word. `crc_o` changes only on that cycle and otherwise holds its value.
- R9: A word carrying both `sof_i` and `eof_i` is a complete frame on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | First word of a frame |
| valid_i | input | 1 | Word qualifier |
| eof_i | input | 1 | Last word of a frame |
| cnt_i | input | 2 | Bytes used in the last word (0 means 4) |
| data_i | input | 32 | Data word, first byte in [7:0] |
| crc_o | output | 32 | Finished CRC, in transmit form |
| done_o | output | 1 | One-cycle strobe after the last word |

## Verification
Two published vectors pin down the conventions. One is a single full word and one is a 24-byte frame spread over several words. Between them they separate errors in bit reversal, byte order, inversion and carrying state from word to word. Random frames of 1 to 64 bytes cover all four residual counts, so each narrow network is exercised from many running states. Random data in the unused bytes shows whether those bytes leak into the result. Idle gaps inside frames, with random data and random flags, show whether anything changes while `valid_i` is low. Repeating one frame after others shows whether start-of-frame really reloads the state.

// File: rtl/crc32_eth_pkg.sv
package crc32_eth_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] POLY = 32'h04C1_1DB7;

  // one byte through the MSB-first shift form; byte is bit-reversed first
  function automatic logic [CRC_W-1:0] byte_step(logic [CRC_W-1:0] s, logic [7:0] b);
    logic [7:0] rev;
    logic fb;
    for (int j = 0; j < 8; j++) rev[j] = b[7-j];
    for (int i = 7; i >= 0; i--) begin
      fb = s[CRC_W-1] ^ rev[i];
      s  = {s[CRC_W-2:0], 1'b0};
      if (fb) s = s ^ POLY;
    end
    return s;
  endfunction
endpackage

// File: rtl/crc32_net.sv
module crc32_net
  import crc32_eth_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [CRC_W-1:0] state_i,
  input  logic [NB*8-1:0]  data_i,
  output logic [CRC_W-1:0] next_o
);
  always_comb begin
    logic [CRC_W-1:0] s;
    s = state_i;
    for (int k = 0; k < NB; k++) s = byte_step(s, data_i[k*8 +: 8]);
    next_o = s;
  end
endmodule

// File: rtl/crc32_fin.sv
module crc32_fin
  import crc32_eth_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  output logic [CRC_W-1:0] crc_o
);
  for (genvar i = 0; i < CRC_W; i++) begin : g_rev
    assign crc_o[i] = ~crc_i[CRC_W-1-i];
  end
endmodule

// File: rtl/crc32_eth_residual.sv
module crc32_eth_residual
  import crc32_eth_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int CNT_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              valid_i,
  input  logic              eof_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  logic [CRC_W-1:0] crc_q, seed, nxt, fin;
  logic [CRC_W-1:0] net_out [BYTES];

  assign seed = sof_i ? '1 : crc_q;

  // one network per possible byte count in the word
  for (genvar k = 1; k <= BYTES; k++) begin : g_net
    crc32_net #(.NB(k)) u_net (
      .state_i(seed),
      .data_i (data_i[k*8-1:0]),
      .next_o (net_out[k-1])
    );
  end

  always_comb begin
    nxt = net_out[BYTES-1];
    for (int k = 1; k < BYTES; k++)
      if (eof_i && cnt_i == CNT_W'(k)) nxt = net_out[k-1];
  end

  crc32_fin u_fin (.crc_i(nxt), .crc_o(fin));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '1;
      crc_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i && eof_i;
      if (valid_i) crc_q <= nxt;
      if (valid_i && eof_i) crc_o <= fin;
    end
  end
endmodule

// File: rtl/crc32_eth_residual_chk.sv
module crc32_eth_residual_chk
  import crc32_eth_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             eof_i,
  input logic [CRC_W-1:0] crc_q,
  input logic [CRC_W-1:0] crc_o,
  input logic             done_o
);
  AST_DONE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> done_o); // R8
  AST_DONE_ONLY_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eof_i) |=> !done_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eof_i) |=> $stable(crc_o)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q)); // R7
  AST_OUT_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$isunknown(crc_o)); // R2
endmodule

bind crc32_eth_residual crc32_eth_residual_chk u_chk (.*);

// File: tb/tb_crc32_eth_residual.sv
module tb_crc32_eth_residual;
  logic clk = 0, rst_ni = 0;
  logic sof = 0, valid = 0, eof = 0;
  logic [1:0] cnt = 0;
  logic [31:0] data = 0;
  logic [31:0] crc;
  logic done;
  int checks = 0, errors = 0;
  logic [7:0] fbuf [64];

  always #5 clk = ~clk;

  crc32_eth_residual dut (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof), .valid_i(valid), .eof_i(eof),
    .cnt_i(cnt), .data_i(data), .crc_o(crc), .done_o(done)
  );

  function automatic logic [31:0] ref_crc(int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      c ^= {24'h0, fbuf[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R7: random idle gaps with random flags and data between words
  task automatic send_frame(int len, bit gaps, logic [31:0] exp, string tag);
    int words = (len + 3) / 4;
    for (int w = 0; w < words; w++) begin
      @(negedge clk);
      sof = (w == 0); valid = 1; eof = (w == words - 1);
      cnt = 2'(len % 4);
      data = $urandom;
      for (int k = 0; k < 4; k++)
        if (w*4 + k < len) data[k*8 +: 8] = fbuf[w*4 + k];
      if (gaps && w != words - 1) begin
        int n = $urandom_range(0, 2);
        for (int g = 0; g < n; g++) begin
          @(negedge clk);
          valid = 0; sof = 1'($urandom); eof = 1'($urandom); data = $urandom;
        end
      end
    end
    @(negedge clk);
    valid = 0; sof = 0; eof = 0;
    check({tag, " crc"}, crc, exp);
    check("R8 done high", {31'h0, done}, 32'h1);
    @(negedge clk);
    check("R8 done one cycle", {31'h0, done}, 32'h0);
    check("R8 crc held", crc, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check("R1 crc reset", crc, 32'h0);
    check("R1 done reset", {31'h0, done}, 32'h0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 crc after release", crc, 32'h0);
    check("R1 done after release", {31'h0, done}, 32'h0);

    // R2 R9: single full word, sof and eof together
    for (int i = 0; i < 4; i++) fbuf[i] = 8'(i + 1);
    send_frame(4, 0, 32'hB63C_FBCD, "R2 R9 word 01020304");
    // R3: single byte in [7:0], upper bytes random
    fbuf[0] = 8'h01;
    send_frame(1, 0, ref_crc(1), "R3 R5 one byte");
    // R6: 24-byte published frame
    for (int i = 0; i < 6; i++) fbuf[i] = 8'(i + 1);
    for (int i = 0; i < 6; i++) fbuf[6 + i] = 8'(8'hF1 + i);
    for (int i = 0; i < 12; i++) fbuf[12 + i] = 8'(i);
    send_frame(24, 1, 32'h0665_4188, "R6 R7 24-byte");
    // R4: same frame after others reloads all ones
    for (int i = 0; i < 4; i++) fbuf[i] = 8'(i + 1);
    send_frame(4, 0, 32'hB63C_FBCD, "R4 reseed");

    // R5 R6 R7: random lengths, all residual counts
    for (int f = 0; f < 200; f++) begin
      int len = (f < 4) ? 61 + f : $urandom_range(1, 64);
      for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
      send_frame(len, 1, ref_crc(len), "R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule